// File: doc/BRIEF.md
# Field-Limited Comparand Rotator and Sliding Mask

This block keeps two 64-bit registers used by a content-addressable search engine: a comparand word and a sliding mask word. On command it moves one of them by one bit position, to the left or to the right, in a single clock. The comparand behaves as a rotator: the bit that leaves one end of the field comes back in at the other end. The mask behaves as a sliding window: the bit that leaves the field is lost, and the bit at the entry end keeps its value while also being copied one place inward.

Both movements act only inside an active field. The field always starts at bit 0, and its width is set by the CAM/RAM partition setting, in steps of a quarter of the word. Bits at or above the field width keep their value during any shift. Either register can be written in parallel through its own load port. A load takes priority over a shift aimed at the same register.

Top module: `shf_cmpmask_shifter`

## Requirements
- R1: While reset is asserted, and after it is released, both `cmp_q` and `msk_q` read all zeros until they are loaded.
- R2: `cmp_load` high at a clock edge makes `cmp_q` equal `cmp_din` after that edge, and `msk_load` does the same for `msk_q` with `msk_din`. When a shift targets a register that is being loaded in the same cycle, the load wins.
- R3: A comparand right shift (`shift_dir`=0) in a field of width W moves bit i+1 to bit i for i < W-1 and puts old bit 0 into bit W-1. W such shifts give back the starting value.
- R4: A comparand left shift (`shift_dir`=1) moves bit i-1 to bit i for 0 < i < W and puts old bit W-1 into bit 0.
- R5: A mask right shift moves bit i+1 to bit i for i < W-1, drops old bit 0, and leaves bit W-1 unchanged. W such shifts fill the field with the old bit W-1.
- R6: A mask left shift moves bit i-1 to bit i for 0 < i < W, drops old bit W-1, and leaves bit 0 unchanged.
- R7: No shift changes any bit at position W or above, in either register.
- R8: `width_sel` sets the field width: 0 gives 16 bits, 1 gives 32, 2 gives 48 and 3 gives 64.
- R9: `shift_sel`=0 picks the comparand and `shift_sel`=1 picks the mask. A shift changes only the picked register. With `shift_en` low and no load, both registers keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Shift the picked register by one bit this cycle |
| shift_dir | input | 1 | 0 = toward bit 0 (right), 1 = toward the top (left) |
| shift_sel | input | 1 | 0 = comparand, 1 = mask |
| width_sel | input | 2 | Field width code: (code+1) x 16 bits |
| cmp_load | input | 1 | Parallel load of the comparand |
| cmp_din | input | 64 | Comparand load value |
| msk_load | input | 1 | Parallel load of the mask |
| msk_din | input | 64 | Mask load value |
| cmp_q | output | 64 | Comparand register |
| msk_q | output | 64 | Mask register |

## Verification
The bench covers every width code, both registers and both directions, using single-bit patterns at bit 0 and at the field top, all-ones words and pseudo-random words. A design that wrapped or replicated at bit 63 and not at the field top would corrupt the bits above a narrow field, or lose the wrapped bit into them. Repeated shifts over the full field width catch a rotator that leaks a bit and a mask that fails to replicate its top bit. Tests of a load in the same cycle as a shift, of idle cycles, and of the register that was not picked catch wrong priority and cross-talk between the two registers.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic {
    DIR_RIGHT = 1'b0,
    DIR_LEFT  = 1'b1
  } shf_dir_e;

  typedef enum logic {
    SEL_CMP = 1'b0,
    SEL_MSK = 1'b1
  } shf_sel_e;

  // Rotation confined to the field: fmask marks field bits, ftop marks the
  // field's top bit (one-hot). Bits outside the field pass through.
  function automatic logic [63:0] rot_field(input logic [63:0] v,
                                            input logic [63:0] fmask,
                                            input logic [63:0] ftop,
                                            input logic        left);
    logic        top_bit;
    logic [63:0] moved;
    top_bit = |(v & ftop);
    if (left) begin
      moved = ((v << 1) & fmask) | {63'd0, top_bit};
    end else begin
      moved = ((v >> 1) & fmask & ~ftop) | (v[0] ? ftop : 64'd0);
    end
    return moved | (v & ~fmask);
  endfunction

  // Sliding shift confined to the field: the entry-end bit is replicated,
  // the exit-end bit is dropped.
  function automatic logic [63:0] slide_field(input logic [63:0] v,
                                              input logic [63:0] fmask,
                                              input logic [63:0] ftop,
                                              input logic        left);
    logic [63:0] moved;
    if (left) begin
      moved = ((v << 1) & fmask) | {63'd0, v[0]};
    end else begin
      moved = ((v >> 1) & fmask & ~ftop) | (v & ftop);
    end
    return moved | (v & ~fmask);
  endfunction

endpackage

// File: rtl/shf_field_decode.sv
module shf_field_decode #(
  parameter int DATA_W = 64,
  parameter int SEGS   = 4,
  localparam int SEG_W = DATA_W / SEGS,
  localparam int SEL_W = $clog2(SEGS)
) (
  input  logic [SEL_W-1:0]  width_sel,
  output logic [DATA_W-1:0] field_mask,
  output logic [DATA_W-1:0] field_top
);

  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    logic seg_on;
    logic seg_top;
    assign seg_on  = (int'(width_sel) >= g);
    assign seg_top = (int'(width_sel) == g);
    assign field_mask[g*SEG_W +: SEG_W] = {SEG_W{seg_on}};
    if (SEG_W > 1) begin : g_wide
      assign field_top[g*SEG_W +: SEG_W] = {seg_top, {(SEG_W-1){1'b0}}};
    end else begin : g_narrow
      assign field_top[g*SEG_W] = seg_top;
    end
  end

endmodule

// File: rtl/shf_rotate_unit.sv
module shf_rotate_unit
  import shf_pkg::*;
(
  input  logic [63:0] cur,
  input  logic [63:0] field_mask,
  input  logic [63:0] field_top,
  input  shf_dir_e    dir,
  output logic [63:0] nxt,
  output logic        wrap_bit
);

  always_comb begin
    nxt      = rot_field(cur, field_mask, field_top, dir == DIR_LEFT);
    wrap_bit = (dir == DIR_LEFT) ? |(cur & field_top) : cur[0];
  end

endmodule

// File: rtl/shf_slide_unit.sv
module shf_slide_unit
  import shf_pkg::*;
(
  input  logic [63:0] cur,
  input  logic [63:0] field_mask,
  input  logic [63:0] field_top,
  input  shf_dir_e    dir,
  output logic [63:0] nxt,
  output logic        edge_bit
);

  always_comb begin
    nxt      = slide_field(cur, field_mask, field_top, dir == DIR_LEFT);
    edge_bit = (dir == DIR_LEFT) ? cur[0] : |(cur & field_top);
  end

endmodule

// File: rtl/shf_reg_slot.sv
module shf_reg_slot #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= din;
    end else if (shift) begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/shf_cmpmask_shifter.sv
module shf_cmpmask_shifter
  import shf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEGS   = 4,
  localparam int SEL_W = $clog2(SEGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_dir,
  input  logic              shift_sel,
  input  logic [SEL_W-1:0]  width_sel,
  input  logic              cmp_load,
  input  logic [DATA_W-1:0] cmp_din,
  input  logic              msk_load,
  input  logic [DATA_W-1:0] msk_din,
  output logic [DATA_W-1:0] cmp_q,
  output logic [DATA_W-1:0] msk_q
);

  logic [DATA_W-1:0] field_mask;
  logic [DATA_W-1:0] field_top;
  logic [DATA_W-1:0] cmp_nxt;
  logic [DATA_W-1:0] msk_nxt;
  logic              cmp_wrap_bit;
  logic              msk_edge_bit;
  logic              cmp_shift_req;
  logic              msk_shift_req;
  logic              cmp_shift_fire;
  logic              msk_shift_fire;
  shf_dir_e          dir;

  assign dir           = shf_dir_e'(shift_dir);
  assign cmp_shift_req = shift_en && (shf_sel_e'(shift_sel) == SEL_CMP);
  assign msk_shift_req = shift_en && (shf_sel_e'(shift_sel) == SEL_MSK);
  assign cmp_shift_fire = cmp_shift_req && !cmp_load;
  assign msk_shift_fire = msk_shift_req && !msk_load;

  shf_field_decode #(.DATA_W(DATA_W), .SEGS(SEGS)) u_field (
    .width_sel  (width_sel),
    .field_mask (field_mask),
    .field_top  (field_top)
  );

  shf_rotate_unit u_rot (
    .cur        (cmp_q),
    .field_mask (field_mask),
    .field_top  (field_top),
    .dir        (dir),
    .nxt        (cmp_nxt),
    .wrap_bit   (cmp_wrap_bit)
  );

  shf_slide_unit u_slide (
    .cur        (msk_q),
    .field_mask (field_mask),
    .field_top  (field_top),
    .dir        (dir),
    .nxt        (msk_nxt),
    .edge_bit   (msk_edge_bit)
  );

  shf_reg_slot #(.W(DATA_W)) u_cmp_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmp_load),
    .din   (cmp_din),
    .shift (cmp_shift_req),
    .nxt   (cmp_nxt),
    .q     (cmp_q)
  );

  shf_reg_slot #(.W(DATA_W)) u_msk_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (msk_load),
    .din   (msk_din),
    .shift (msk_shift_req),
    .nxt   (msk_nxt),
    .q     (msk_q)
  );

endmodule

// File: rtl/shf_cmpmask_checker.sv
module shf_cmpmask_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_en,
  input logic              shift_dir,
  input logic              cmp_load,
  input logic [DATA_W-1:0] cmp_din,
  input logic              msk_load,
  input logic [DATA_W-1:0] msk_din,
  input logic [DATA_W-1:0] cmp_q,
  input logic [DATA_W-1:0] msk_q,
  input logic [DATA_W-1:0] field_mask,
  input logic [DATA_W-1:0] field_top,
  input logic              cmp_wrap_bit,
  input logic              msk_edge_bit,
  input logic              cmp_shift_fire,
  input logic              msk_shift_fire
);

  assert_load_cmp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_load |=> cmp_q == $past(cmp_din));

  assert_load_msk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    msk_load |=> msk_q == $past(msk_din));

  assert_rot_right_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_shift_fire && !shift_dir) |=> (|(cmp_q & $past(field_top))) == $past(cmp_wrap_bit));

  assert_rot_keeps_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_shift_fire |=> $countones(cmp_q) == $countones($past(cmp_q)));

  assert_rot_left_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_shift_fire && shift_dir) |=> cmp_q[0] == $past(cmp_wrap_bit));

  assert_mask_right_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_shift_fire && !shift_dir) |=> (|(msk_q & $past(field_top))) == $past(msk_edge_bit));

  assert_mask_left_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_shift_fire && shift_dir) |=> msk_q[0] == $past(msk_q[0]));

  assert_cmp_above_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_shift_fire |=> (cmp_q & ~$past(field_mask)) == ($past(cmp_q) & ~$past(field_mask)));

  assert_msk_above_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msk_shift_fire |=> (msk_q & ~$past(field_mask)) == ($past(msk_q) & ~$past(field_mask)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !cmp_load && !msk_load) |=> ($stable(cmp_q) && $stable(msk_q)));

  assert_cmp_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_shift_fire && !cmp_load) |=> $stable(cmp_q));

  assert_msk_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_shift_fire && !msk_load) |=> $stable(msk_q));

endmodule

bind shf_cmpmask_shifter shf_cmpmask_checker #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .shift_en       (shift_en),
  .shift_dir      (shift_dir),
  .cmp_load       (cmp_load),
  .cmp_din        (cmp_din),
  .msk_load       (msk_load),
  .msk_din        (msk_din),
  .cmp_q          (cmp_q),
  .msk_q          (msk_q),
  .field_mask     (field_mask),
  .field_top      (field_top),
  .cmp_wrap_bit   (cmp_wrap_bit),
  .msk_edge_bit   (msk_edge_bit),
  .cmp_shift_fire (cmp_shift_fire),
  .msk_shift_fire (msk_shift_fire)
);

// File: tb/test_shf_cmpmask_shifter.sv
`timescale 1ns/1ps
module test_shf_cmpmask_shifter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shift_en = 1'b0;
  logic        shift_dir = 1'b0;
  logic        shift_sel = 1'b0;
  logic [1:0]  width_sel = 2'd3;
  logic        cmp_load = 1'b0;
  logic [63:0] cmp_din = '0;
  logic        msk_load = 1'b0;
  logic [63:0] msk_din = '0;
  logic [63:0] cmp_q;
  logic [63:0] msk_q;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  shf_cmpmask_shifter i_shf_cmpmask_shifter (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_dir(shift_dir),
    .shift_sel(shift_sel), .width_sel(width_sel), .cmp_load(cmp_load),
    .cmp_din(cmp_din), .msk_load(msk_load), .msk_din(msk_din),
    .cmp_q(cmp_q), .msk_q(msk_q)
  );

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  // Bit-by-bit model of one shift in a field of w bits.
  function automatic logic [63:0] model(input logic [63:0] v, input int w,
                                        input bit left, input bit is_mask);
    logic [63:0] r;
    r = v;
    for (int i = 0; i < w; i++) begin
      if (!left) begin
        if (i == w - 1) r[i] = is_mask ? v[i] : v[0];
        else            r[i] = v[i+1];
      end else begin
        if (i == 0) r[i] = is_mask ? v[0] : v[w-1];
        else        r[i] = v[i-1];
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] low_ones(input int w);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_both(input logic [63:0] a, input logic [63:0] b);
    cmp_load = 1'b1; cmp_din = a;
    msk_load = 1'b1; msk_din = b;
    tick();
    cmp_load = 1'b0; msk_load = 1'b0;
  endtask

  task automatic shift_once(input bit sel, input bit dir);
    shift_en = 1'b1; shift_sel = sel; shift_dir = dir;
    tick();
    shift_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] a, b, fm, cmp_exp, msk_exp, start;
    int w;
    string tag;
    @(negedge clk);
    check("R1 reset cmp", cmp_q, 64'd0);
    check("R1 reset msk", msk_q, 64'd0);
    tick();
    rst_n = 1'b1;
    tick();
    check("R1 after release cmp", cmp_q, 64'd0);
    check("R1 after release msk", msk_q, 64'd0);

    // Sweep: width code (R8), register, direction, pattern.
    for (int ws = 0; ws < 4; ws++) begin
      w = (ws + 1) * 16;
      fm = low_ones(w);
      width_sel = 2'(ws);
      for (int sel = 0; sel < 2; sel++) begin
        for (int dir = 0; dir < 2; dir++) begin
          for (int p = 0; p < 8; p++) begin
            seed = next_rand(seed); a = seed;
            seed = next_rand(seed); b = seed;
            if (p == 0) begin a = 64'd1; b = 64'd1; end
            if (p == 1) begin a = 64'd1 << (w - 1); b = 64'd1 << (w - 1); end
            if (p == 2) begin a = '1; b = ~(64'd1 << (w - 1)); end
            if (p == 3) begin a = 64'd1 << w; b = ~64'd1; end
            load_both(a, b);
            check("R2 load cmp", cmp_q, a);
            check("R2 load msk", msk_q, b);
            shift_once(sel[0], dir[0]);
            if (sel == 0) begin
              cmp_exp = model(a, w, dir[0], 1'b0);
              msk_exp = b;
              tag = (dir == 0) ? "R3 rotate right" : "R4 rotate left";
              check(tag, cmp_q, cmp_exp);
              check("R9 mask untouched", msk_q, msk_exp);
              check("R7 R8 cmp above field", cmp_q & ~fm, a & ~fm);
            end else begin
              msk_exp = model(b, w, dir[0], 1'b1);
              cmp_exp = a;
              tag = (dir == 0) ? "R5 mask right" : "R6 mask left";
              check(tag, msk_q, msk_exp);
              check("R9 comparand untouched", cmp_q, cmp_exp);
              check("R7 R8 msk above field", msk_q & ~fm, b & ~fm);
            end
          end
        end
      end
    end

    // Load beats a same-cycle shift of the same register.
    width_sel = 2'd1;
    load_both(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
    cmp_load = 1'b1; cmp_din = 64'hAAAA_0000_5555_FFFF;
    shift_en = 1'b1; shift_sel = 1'b0; shift_dir = 1'b1;
    tick();
    cmp_load = 1'b0; shift_en = 1'b0;
    check("R2 load over cmp shift", cmp_q, 64'hAAAA_0000_5555_FFFF);
    msk_load = 1'b1; msk_din = 64'h1111_2222_3333_4444;
    shift_en = 1'b1; shift_sel = 1'b1; shift_dir = 1'b0;
    tick();
    msk_load = 1'b0; shift_en = 1'b0;
    check("R2 load over msk shift", msk_q, 64'h1111_2222_3333_4444);

    // Idle cycles hold both registers.
    shift_dir = 1'b1;
    for (int k = 0; k < 3; k++) tick();
    check("R9 idle cmp", cmp_q, 64'hAAAA_0000_5555_FFFF);
    check("R9 idle msk", msk_q, 64'h1111_2222_3333_4444);

    // Full turns of the rotator return the start value.
    width_sel = 2'd1;
    start = 64'hDEAD_BEEF_8000_0013;
    load_both(start, 64'd0);
    for (int k = 0; k < 32; k++) shift_once(1'b0, 1'b0);
    check("R3 32 right rotations", cmp_q, start);
    width_sel = 2'd0;
    for (int k = 0; k < 16; k++) shift_once(1'b0, 1'b1);
    check("R4 16 left rotations", cmp_q, start);

    // Repeated mask right shifts fill the field with the old top bit.
    width_sel = 2'd2;
    a = 64'hF0F0_8000_1234_5678;
    load_both(64'd0, a);
    for (int k = 0; k < 48; k++) shift_once(1'b1, 1'b0);
    check("R5 48 right slides", msk_q, (a & ~low_ones(48)) | low_ones(48));
    // Repeated mask left shifts fill the field with the old bit 0.
    width_sel = 2'd0;
    a = 64'h5A5A_0000_0000_FFFE;
    load_both(64'd0, a);
    for (int k = 0; k < 16; k++) shift_once(1'b1, 1'b1);
    check("R6 16 left slides", msk_q, a & ~low_ones(16));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule